// File: doc/BRIEF.md
# Paired-Page Translation Lookaside Buffer

This block is a fully associative address translation cache. Each entry maps one pair of adjacent virtual pages onto two physical frames: an even frame and an odd frame. Each half carries its own valid, dirty, read-inhibit and execute-inhibit flags. Each entry also has a programmable page mask, so one entry can cover a pair of large pages.

A lookup presents a virtual address, an access kind (fetch, load or store) and the current address-space identifier. One cycle later the block returns a result code, a physical address and a writable flag. Entries are loaded through a simple indexed write port that supplies all fields of one entry in a single cycle. Refill handling and replacement policy belong to the surrounding logic.

Top module: `ptlb_lookup`

## Requirements
- R1: After reset, and until the first entry write, every lookup returns code 1 (no-match), a physical address of 0 and writable 0.
- R2: An entry hits only when its hardware-invalidate flag is clear, its masked VPN equals the masked address, and either its global flag is set or its stored ASID equals the lookup ASID.
- R3: The effective mask of an entry is the written page mask ORed with 0x1FFF. Address and VPN bits under the effective mask take no part in the comparison, so pages are never smaller than 4 KiB.
- R4: The half is chosen by the highest address bit covered by the effective mask (bit 12 for 4 KiB pages). A 0 selects the even half and a 1 selects the odd half.
- R5: On code 0 the physical address is the selected frame base ORed with the address bits below the half-page boundary (address AND effective-mask>>1).
- R6: Half flags are encoded as bit0 valid, bit1 dirty, bit2 read-inhibit and bit3 execute-inhibit. Access kinds are encoded as 0 fetch, 1 load, 2 store, and 3 behaves as a load. On a hit the checks run in this order: valid clear gives code 2 (invalid); a fetch with execute-inhibit set gives code 5; a load with read-inhibit set gives code 4; a store with dirty clear gives code 3 (modified); otherwise the code is 0 (match).
- R7: Writable is 1 only when the code is 0 and the selected half's dirty flag is set. Every match grants read access.
- R8: When several entries hit, the entry with the lowest index supplies the result.
- R9: A result appears with result-valid exactly one cycle after a lookup is presented. A lookup in the same cycle as an entry write sees the old entry contents. Lookups from the next cycle onward see the new contents.
- R10: When no entry hits the code is 1. For any code other than 0 the physical address and writable outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write one entry this cycle |
| wr_idx | input | 4 | Entry index to write |
| wr_vpn | input | 32 | Virtual page-pair address |
| wr_mask | input | 32 | Page mask (bits above 12 widen the page) |
| wr_asid | input | 8 | Entry address-space identifier |
| wr_global | input | 1 | Entry matches any ASID |
| wr_hinv | input | 1 | Entry hardware-invalidated |
| wr_pfn_even | input | 32 | Physical frame base of the even half |
| wr_pfn_odd | input | 32 | Physical frame base of the odd half |
| wr_flags_even | input | 4 | Even half flags {xi, ri, dirty, valid} |
| wr_flags_odd | input | 4 | Odd half flags {xi, ri, dirty, valid} |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_va | input | 32 | Virtual address to translate |
| lk_kind | input | 2 | Access kind |
| lk_asid | input | 8 | Current address-space identifier |
| rs_valid | output | 1 | Result valid |
| rs_code | output | 3 | Result code |
| rs_pa | output | 32 | Translated physical address |
| rs_writable | output | 1 | Write permission granted |

## Verification
A corrupted stored field reaches the ports on the first lookup that selects the entry, one cycle after that lookup. A damaged tag or ASID shows up as a spurious code 1. A wrong half selection shows up as a foreign frame base or a permission code taken from the other half. A wrong priority or permission order shows up as a different code or address in that same result. Any lookup made before the first write exposes a reset that leaves an entry live, because it returns something other than no-match.

// File: rtl/ptlb_pkg.sv
package ptlb_pkg;

  // Offset bits covered by every entry: a 4 KiB page pair.
  localparam int unsigned MIN_PAIR_BITS = 13;

  typedef enum logic [2:0] {
    RC_MATCH    = 3'd0,
    RC_NOMATCH  = 3'd1,
    RC_INVALID  = 3'd2,
    RC_MODIFIED = 3'd3,
    RC_RDINH    = 3'd4,
    RC_EXINH    = 3'd5
  } res_code_t;

  typedef enum logic [1:0] {
    AK_FETCH    = 2'd0,
    AK_LOAD     = 2'd1,
    AK_STORE    = 2'd2,
    AK_LOAD_ALT = 2'd3
  } acc_kind_t;

  typedef struct packed {
    logic xinh;
    logic rinh;
    logic dirty;
    logic valid;
  } half_flags_t;

endpackage

// File: rtl/ptlb_store.sv
module ptlb_store
  import ptlb_pkg::*;
#(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned VA_W    = 32,
  parameter int unsigned PA_W    = 32,
  parameter int unsigned ASID_W  = 8,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VA_W-1:0]   wr_vpn,
  input  logic [VA_W-1:0]   wr_mask,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_global,
  input  logic              wr_hinv,
  input  logic [PA_W-1:0]   wr_pfn_even,
  input  logic [PA_W-1:0]   wr_pfn_odd,
  input  half_flags_t       wr_flags_even,
  input  half_flags_t       wr_flags_odd,
  output logic [VA_W-1:0]   ent_vpn   [ENTRIES],
  output logic [VA_W-1:0]   ent_mask  [ENTRIES],
  output logic [ASID_W-1:0] ent_asid  [ENTRIES],
  output logic              ent_glob  [ENTRIES],
  output logic              ent_hinv  [ENTRIES],
  output logic [PA_W-1:0]   ent_pfn_e [ENTRIES],
  output logic [PA_W-1:0]   ent_pfn_o [ENTRIES],
  output half_flags_t       ent_fl_e  [ENTRIES],
  output half_flags_t       ent_fl_o  [ENTRIES]
);

  localparam logic [VA_W-1:0] LOW_MASK = VA_W'((64'd1 << MIN_PAIR_BITS) - 64'd1);

  logic [VA_W-1:0] eff_mask_d;

  always_comb begin
    eff_mask_d = wr_mask | LOW_MASK;
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic sel;

    always_comb begin
      sel = wr_en && (wr_idx == IDX_W'(g));
    end

    // Only the invalidate flag is reset: it alone decides liveness.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_hinv[g] <= 1'b1;
      end else if (sel) begin
        ent_hinv[g] <= wr_hinv;
      end
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        ent_vpn[g]   <= wr_vpn;
        ent_mask[g]  <= eff_mask_d;
        ent_asid[g]  <= wr_asid;
        ent_glob[g]  <= wr_global;
        ent_pfn_e[g] <= wr_pfn_even;
        ent_pfn_o[g] <= wr_pfn_odd;
        ent_fl_e[g]  <= wr_flags_even;
        ent_fl_o[g]  <= wr_flags_odd;
      end
    end
  end

endmodule

// File: rtl/ptlb_match.sv
module ptlb_match #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned VA_W    = 32,
  parameter int unsigned ASID_W  = 8
) (
  input  logic [VA_W-1:0]   lk_va,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [VA_W-1:0]   ent_vpn  [ENTRIES],
  input  logic [VA_W-1:0]   ent_mask [ENTRIES],
  input  logic [ASID_W-1:0] ent_asid [ENTRIES],
  input  logic              ent_glob [ENTRIES],
  input  logic              ent_hinv [ENTRIES],
  output logic [ENTRIES-1:0] hit_vec,
  output logic [ENTRIES-1:0] odd_vec
);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    logic            tag_eq;
    logic            asid_ok;
    logic [VA_W-1:0] top_bit;

    always_comb begin
      tag_eq     = ((lk_va ^ ent_vpn[g]) & ~ent_mask[g]) == '0;
      asid_ok    = ent_glob[g] || (ent_asid[g] == lk_asid);
      hit_vec[g] = tag_eq && asid_ok && !ent_hinv[g];
      // Highest bit covered by the mask picks the half.
      top_bit    = ent_mask[g] & ~(ent_mask[g] >> 1);
      odd_vec[g] = |(lk_va & top_bit);
    end
  end

endmodule

// File: rtl/ptlb_resolve.sv
module ptlb_resolve
  import ptlb_pkg::*;
#(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned VA_W    = 32,
  parameter int unsigned PA_W    = 32,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic [VA_W-1:0]    lk_va,
  input  acc_kind_t          lk_kind,
  input  logic [ENTRIES-1:0] hit_vec,
  input  logic [ENTRIES-1:0] odd_vec,
  input  logic [VA_W-1:0]    ent_mask  [ENTRIES],
  input  logic [PA_W-1:0]    ent_pfn_e [ENTRIES],
  input  logic [PA_W-1:0]    ent_pfn_o [ENTRIES],
  input  half_flags_t        ent_fl_e  [ENTRIES],
  input  half_flags_t        ent_fl_o  [ENTRIES],
  output res_code_t          c_code,
  output logic [PA_W-1:0]    c_pa,
  output logic               c_writable
);

  logic [IDX_W-1:0] pick;
  logic             any_hit;
  logic             is_odd;
  half_flags_t      fl;
  logic [PA_W-1:0]  frame;
  logic [VA_W-1:0]  half_off;
  logic             is_load;

  // Lowest index wins: scan downward so the last assignment is the lowest.
  always_comb begin
    pick    = '0;
    any_hit = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        pick    = IDX_W'(i);
        any_hit = 1'b1;
      end
    end
  end

  always_comb begin
    is_odd   = odd_vec[pick];
    fl       = is_odd ? ent_fl_o[pick]  : ent_fl_e[pick];
    frame    = is_odd ? ent_pfn_o[pick] : ent_pfn_e[pick];
    half_off = ent_mask[pick] >> 1;
    is_load  = (lk_kind == AK_LOAD) || (lk_kind == AK_LOAD_ALT);
  end

  always_comb begin
    if (!any_hit) begin
      c_code = RC_NOMATCH;
    end else if (!fl.valid) begin
      c_code = RC_INVALID;
    end else if ((lk_kind == AK_FETCH) && fl.xinh) begin
      c_code = RC_EXINH;
    end else if (is_load && fl.rinh) begin
      c_code = RC_RDINH;
    end else if ((lk_kind == AK_STORE) && !fl.dirty) begin
      c_code = RC_MODIFIED;
    end else begin
      c_code = RC_MATCH;
    end
  end

  always_comb begin
    if (c_code == RC_MATCH) begin
      c_pa       = frame | PA_W'(lk_va & half_off);
      c_writable = fl.dirty;
    end else begin
      c_pa       = '0;
      c_writable = 1'b0;
    end
  end

endmodule

// File: rtl/ptlb_lookup.sv
module ptlb_lookup
  import ptlb_pkg::*;
#(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned VA_W    = 32,
  parameter int unsigned PA_W    = 32,
  parameter int unsigned ASID_W  = 8,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VA_W-1:0]   wr_vpn,
  input  logic [VA_W-1:0]   wr_mask,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_global,
  input  logic              wr_hinv,
  input  logic [PA_W-1:0]   wr_pfn_even,
  input  logic [PA_W-1:0]   wr_pfn_odd,
  input  logic [3:0]        wr_flags_even,
  input  logic [3:0]        wr_flags_odd,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_va,
  input  logic [1:0]        lk_kind,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              rs_valid,
  output logic [2:0]        rs_code,
  output logic [PA_W-1:0]   rs_pa,
  output logic              rs_writable
);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_pipe;
  logic       rst_n_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end

  always_comb begin
    rst_n_sync = rst_pipe[1];
  end

  logic [VA_W-1:0]   ent_vpn   [ENTRIES];
  logic [VA_W-1:0]   ent_mask  [ENTRIES];
  logic [ASID_W-1:0] ent_asid  [ENTRIES];
  logic              ent_glob  [ENTRIES];
  logic              ent_hinv  [ENTRIES];
  logic [PA_W-1:0]   ent_pfn_e [ENTRIES];
  logic [PA_W-1:0]   ent_pfn_o [ENTRIES];
  half_flags_t       ent_fl_e  [ENTRIES];
  half_flags_t       ent_fl_o  [ENTRIES];

  ptlb_store #(
    .ENTRIES(ENTRIES), .VA_W(VA_W), .PA_W(PA_W), .ASID_W(ASID_W)
  ) u_store (
    .clk          (clk),
    .rst_n        (rst_n_sync),
    .wr_en        (wr_en),
    .wr_idx       (wr_idx),
    .wr_vpn       (wr_vpn),
    .wr_mask      (wr_mask),
    .wr_asid      (wr_asid),
    .wr_global    (wr_global),
    .wr_hinv      (wr_hinv),
    .wr_pfn_even  (wr_pfn_even),
    .wr_pfn_odd   (wr_pfn_odd),
    .wr_flags_even(half_flags_t'(wr_flags_even)),
    .wr_flags_odd (half_flags_t'(wr_flags_odd)),
    .ent_vpn      (ent_vpn),
    .ent_mask     (ent_mask),
    .ent_asid     (ent_asid),
    .ent_glob     (ent_glob),
    .ent_hinv     (ent_hinv),
    .ent_pfn_e    (ent_pfn_e),
    .ent_pfn_o    (ent_pfn_o),
    .ent_fl_e     (ent_fl_e),
    .ent_fl_o     (ent_fl_o)
  );

  logic [ENTRIES-1:0] hit_vec;
  logic [ENTRIES-1:0] odd_vec;

  ptlb_match #(
    .ENTRIES(ENTRIES), .VA_W(VA_W), .ASID_W(ASID_W)
  ) u_match (
    .lk_va   (lk_va),
    .lk_asid (lk_asid),
    .ent_vpn (ent_vpn),
    .ent_mask(ent_mask),
    .ent_asid(ent_asid),
    .ent_glob(ent_glob),
    .ent_hinv(ent_hinv),
    .hit_vec (hit_vec),
    .odd_vec (odd_vec)
  );

  res_code_t       c_code;
  logic [PA_W-1:0] c_pa;
  logic            c_writable;

  ptlb_resolve #(
    .ENTRIES(ENTRIES), .VA_W(VA_W), .PA_W(PA_W)
  ) u_resolve (
    .lk_va     (lk_va),
    .lk_kind   (acc_kind_t'(lk_kind)),
    .hit_vec   (hit_vec),
    .odd_vec   (odd_vec),
    .ent_mask  (ent_mask),
    .ent_pfn_e (ent_pfn_e),
    .ent_pfn_o (ent_pfn_o),
    .ent_fl_e  (ent_fl_e),
    .ent_fl_o  (ent_fl_o),
    .c_code    (c_code),
    .c_pa      (c_pa),
    .c_writable(c_writable)
  );

  // Result register: next state, then the flops.
  logic            valid_d;
  res_code_t       code_q;
  logic [PA_W-1:0] pa_q;
  logic            wr_q;

  always_comb begin
    valid_d = lk_valid;
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      rs_valid <= 1'b0;
      code_q   <= RC_NOMATCH;
      pa_q     <= '0;
      wr_q     <= 1'b0;
    end else begin
      rs_valid <= valid_d;
      if (lk_valid) begin
        code_q <= c_code;
        pa_q   <= c_pa;
        wr_q   <= c_writable;
      end
    end
  end

  always_comb begin
    rs_code     = code_q;
    rs_pa       = pa_q;
    rs_writable = wr_q;
  end

endmodule

// File: rtl/ptlb_chk.sv
module ptlb_chk #(
  parameter int unsigned PA_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic            lk_valid,
  input logic [1:0]      lk_kind,
  input logic            rs_valid,
  input logic [2:0]      rs_code,
  input logic [PA_W-1:0] rs_pa,
  input logic            rs_writable
);

  logic wrote_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrote_q <= 1'b0;
    end else if (wr_en) begin
      wrote_q <= 1'b1;
    end
  end

  // R1
  empty_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && !wrote_q |=> rs_code == 3'd1);

  // R9
  result_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rs_valid);

  // R9
  no_spurious_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rs_valid);

  // R7
  write_needs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid && rs_writable |-> rs_code == 3'd0);

  // R10
  pa_zero_on_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid && rs_code != 3'd0 |-> rs_pa == '0);

  // R6
  code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid |-> rs_code <= 3'd5);

  // R6
  fetch_codes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && lk_kind == 2'd0 |=> rs_code != 3'd4 && rs_code != 3'd3);

  // R7
  store_match_writable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && lk_kind == 2'd2 |=> rs_code != 3'd0 || rs_writable);

endmodule

bind ptlb_lookup ptlb_chk #(.PA_W(PA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n_sync),
  .wr_en      (wr_en),
  .lk_valid   (lk_valid),
  .lk_kind    (lk_kind),
  .rs_valid   (rs_valid),
  .rs_code    (rs_code),
  .rs_pa      (rs_pa),
  .rs_writable(rs_writable)
);

// File: tb/ptlb_lookup_tb.sv
`timescale 1ns/1ps
module ptlb_lookup_tb;

  localparam logic [3:0] FV = 4'b0001;
  localparam logic [3:0] FD = 4'b0010;
  localparam logic [3:0] FR = 4'b0100;
  localparam logic [3:0] FX = 4'b1000;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_idx;
  logic [31:0] wr_vpn, wr_mask, wr_pfn_even, wr_pfn_odd;
  logic [7:0]  wr_asid;
  logic        wr_global, wr_hinv;
  logic [3:0]  wr_flags_even, wr_flags_odd;
  logic        lk_valid;
  logic [31:0] lk_va;
  logic [1:0]  lk_kind;
  logic [7:0]  lk_asid;
  logic        rs_valid;
  logic [2:0]  rs_code;
  logic [31:0] rs_pa;
  logic        rs_writable;

  int checks;
  int fails;

  logic [2:0]  q_code[$];
  logic [31:0] q_pa[$];
  logic        q_wr[$];
  string       q_tag[$];

  ptlb_lookup u_dut (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_mask(wr_mask),
    .wr_asid(wr_asid), .wr_global(wr_global), .wr_hinv(wr_hinv),
    .wr_pfn_even(wr_pfn_even), .wr_pfn_odd(wr_pfn_odd),
    .wr_flags_even(wr_flags_even), .wr_flags_odd(wr_flags_odd),
    .lk_valid(lk_valid), .lk_va(lk_va), .lk_kind(lk_kind), .lk_asid(lk_asid),
    .rs_valid(rs_valid), .rs_code(rs_code), .rs_pa(rs_pa), .rs_writable(rs_writable)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic set_wr(input logic [3:0] idx, input logic [31:0] vpn, input logic [31:0] mask,
                        input logic [7:0] asid, input logic g, input logic hinv,
                        input logic [31:0] pe, input logic [31:0] po,
                        input logic [3:0] fe, input logic [3:0] fo);
    wr_en = 1'b1; wr_idx = idx; wr_vpn = vpn; wr_mask = mask; wr_asid = asid;
    wr_global = g; wr_hinv = hinv; wr_pfn_even = pe; wr_pfn_odd = po;
    wr_flags_even = fe; wr_flags_odd = fo;
  endtask

  task automatic set_lk(input logic [31:0] va, input logic [1:0] kind, input logic [7:0] asid,
                        input logic [2:0] ec, input logic [31:0] epa, input logic ew,
                        input string tag);
    lk_valid = 1'b1; lk_va = va; lk_kind = kind; lk_asid = asid;
    q_code.push_back(ec); q_pa.push_back(epa); q_wr.push_back(ew); q_tag.push_back(tag);
  endtask

  task automatic wr_entry(input logic [3:0] idx, input logic [31:0] vpn, input logic [31:0] mask,
                          input logic [7:0] asid, input logic g, input logic hinv,
                          input logic [31:0] pe, input logic [31:0] po,
                          input logic [3:0] fe, input logic [3:0] fo);
    @(negedge clk);
    lk_valid = 1'b0;
    set_wr(idx, vpn, mask, asid, g, hinv, pe, po, fe, fo);
  endtask

  task automatic lookup(input logic [31:0] va, input logic [1:0] kind, input logic [7:0] asid,
                        input logic [2:0] ec, input logic [31:0] epa, input logic ew,
                        input string tag);
    @(negedge clk);
    wr_en = 1'b0;
    set_lk(va, kind, asid, ec, epa, ew, tag);
  endtask

  task automatic idle();
    @(negedge clk);
    wr_en = 1'b0;
    lk_valid = 1'b0;
  endtask

  // Monitor: pops one expectation per valid result.
  always @(negedge clk) begin
    if (rst_n && rs_valid) begin
      checks++;
      if (q_code.size() == 0) begin
        fails++;
        $display("FAIL R9 unexpected result code=%0d pa=%h expected none", rs_code, rs_pa);
      end else begin
        logic [2:0]  ec;
        logic [31:0] epa;
        logic        ew;
        string       tg;
        ec = q_code.pop_front(); epa = q_pa.pop_front();
        ew = q_wr.pop_front();   tg = q_tag.pop_front();
        if (rs_code !== ec || rs_pa !== epa || rs_writable !== ew) begin
          fails++;
          $display("FAIL %s code=%0d pa=%h wr=%0d expected code=%0d pa=%h wr=%0d",
                   tg, rs_code, rs_pa, rs_writable, ec, epa, ew);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired: actual hung expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    checks = 0; fails = 0;
    rst_n = 1'b0; wr_en = 1'b0; lk_valid = 1'b0;
    wr_idx = '0; wr_vpn = '0; wr_mask = '0; wr_asid = '0; wr_global = 1'b0; wr_hinv = 1'b0;
    wr_pfn_even = '0; wr_pfn_odd = '0; wr_flags_even = '0; wr_flags_odd = '0;
    lk_va = '0; lk_kind = '0; lk_asid = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state at the ports
    checks++;
    if (rs_valid !== 1'b0 || rs_code !== 3'd1 || rs_pa !== 32'h0 || rs_writable !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset valid=%0d code=%0d pa=%h wr=%0d expected 0 1 0 0",
               rs_valid, rs_code, rs_pa, rs_writable);
    end
    lookup(32'h0040_0123, 2'd1, 8'd5, 3'd1, 32'h0, 1'b0, "R1 empty table");
    lookup(32'hFFFF_F000, 2'd0, 8'd0, 3'd1, 32'h0, 1'b0, "R1 empty table fetch");

    // Entry 0: 4 KiB pair, ASID 5, even V|D, odd V
    wr_entry(4'd0, 32'h0040_0000, 32'h0, 8'd5, 1'b0, 1'b0,
             32'h1000_0000, 32'h2000_0000, FV | FD, FV);
    lookup(32'h0040_0123, 2'd1, 8'd5, 3'd0, 32'h1000_0123, 1'b1, "R5 even load");
    lookup(32'h0040_1456, 2'd2, 8'd5, 3'd3, 32'h0, 1'b0, "R4 odd store not dirty");
    lookup(32'h0040_1456, 2'd1, 8'd5, 3'd0, 32'h2000_0456, 1'b0, "R7 odd read only");
    lookup(32'h0040_0123, 2'd1, 8'd6, 3'd1, 32'h0, 1'b0, "R2 asid mismatch");
    lookup(32'h0041_0123, 2'd1, 8'd5, 3'd1, 32'h0, 1'b0, "R10 tag mismatch");

    // Entry 1: global 16 KiB pair
    wr_entry(4'd1, 32'h0080_0000, 32'h0000_6000, 8'd9, 1'b1, 1'b0,
             32'h3000_0000, 32'h3100_0000, FV | FX, FV | FD | FR);
    lookup(32'h0080_2345, 2'd0, 8'd1, 3'd5, 32'h0, 1'b0, "R6 exec inhibit global");
    lookup(32'h0080_2345, 2'd1, 8'd1, 3'd0, 32'h3000_2345, 1'b0, "R3 large page load");
    lookup(32'h0080_4ABC, 2'd1, 8'd1, 3'd4, 32'h0, 1'b0, "R6 read inhibit");
    lookup(32'h0080_4ABC, 2'd3, 8'd1, 3'd4, 32'h0, 1'b0, "R6 kind 3 as load");
    lookup(32'h0080_7FFC, 2'd2, 8'd1, 3'd0, 32'h3100_3FFC, 1'b1, "R4 odd store dirty");
    lookup(32'h0080_4000, 2'd0, 8'd1, 3'd0, 32'h3100_0000, 1'b1, "R6 fetch ignores ri");

    // Entry 2: even invalid with xi set, odd V|D
    wr_entry(4'd2, 32'h00C0_0000, 32'h0, 8'd5, 1'b0, 1'b0,
             32'h0B00_0000, 32'h0C00_0000, FX, FV | FD);
    lookup(32'h00C0_0010, 2'd0, 8'd5, 3'd2, 32'h0, 1'b0, "R6 invalid before xi");
    lookup(32'h00C0_1000, 2'd2, 8'd5, 3'd0, 32'h0C00_0000, 1'b1, "R7 store match dirty");

    // Entry 3: hardware-invalidated global entry
    wr_entry(4'd3, 32'h0100_0000, 32'h0, 8'd0, 1'b1, 1'b1,
             32'h7000_0000, 32'h7100_0000, FV | FD, FV | FD);
    lookup(32'h0100_0000, 2'd1, 8'd0, 3'd1, 32'h0, 1'b0, "R2 hinv blocks hit");

    // Entry 6: low VPN bits ignored
    wr_entry(4'd6, 32'h0300_1FFF, 32'h0, 8'd0, 1'b1, 1'b0,
             32'h6000_0000, 32'h6100_0000, FV | FD, FV);
    lookup(32'h0300_0004, 2'd1, 8'd3, 3'd0, 32'h6000_0004, 1'b1, "R3 low vpn bits ignored");

    // Entries 4 and 5 overlap
    wr_entry(4'd5, 32'h0200_0000, 32'h0, 8'd0, 1'b1, 1'b0,
             32'h5500_0000, 32'h5500_1000, FV | FD, FV);
    wr_entry(4'd4, 32'h0200_0000, 32'h0, 8'd0, 1'b1, 1'b0,
             32'h4400_0000, 32'h4400_1000, FV | FD, FV);
    lookup(32'h0200_0010, 2'd1, 8'd2, 3'd0, 32'h4400_0010, 1'b1, "R8 lowest index wins");
    wr_entry(4'd4, 32'h0200_0000, 32'h0, 8'd0, 1'b1, 1'b1,
             32'h4400_0000, 32'h4400_1000, FV | FD, FV);
    lookup(32'h0200_0010, 2'd1, 8'd2, 3'd0, 32'h5500_0010, 1'b1, "R8 fallback to next entry");

    // Same-cycle write and lookup
    @(negedge clk);
    set_wr(4'd0, 32'h0040_0000, 32'h0, 8'd5, 1'b0, 1'b0,
           32'h1A00_0000, 32'h2000_0000, FV | FD, FV);
    set_lk(32'h0040_0123, 2'd1, 8'd5, 3'd0, 32'h1000_0123, 1'b1, "R9 same cycle sees old");
    lookup(32'h0040_0123, 2'd1, 8'd5, 3'd0, 32'h1A00_0123, 1'b1, "R9 next cycle sees new");
    idle();
    idle();

    repeat (4) @(negedge clk);
    checks++;
    if (q_code.size() != 0) begin
      fails++;
      $display("FAIL R9 results missing: actual %0d pending expected 0", q_code.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule